// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that gives a host read and write access to a bank of byte-wide configuration registers. The address space holds up to 128 locations. The host drives an active-low chip-select, a serial clock and a serial data line. The block answers on a dedicated data output, or it turns read data around onto the shared data line when three-wire operation is selected. All pins are oversampled by the block's own system clock through a synchronizer, so the whole block runs in one clock domain.

Every transfer opens with an 8-bit header: a read/write flag and a 7-bit register address. One or more data bytes follow, and the address steps up by one after each data byte. The host may pause between bytes by raising chip-select. Raising it partway through a byte abandons the transfer. A pause longer than a set number of system clocks closes the transfer, so the next low level on chip-select begins a new header.

Register 0 is the mode register. It selects three-wire operation, least-significant-bit-first order and a software reset. Each of these controls has a mirror bit in the low half of the register, so a host that is unsure of the bit order still sets it correctly. The other registers load computed default values whenever the power-on reset or the external reset pin is active. They also hold those defaults while the software reset is set.

Top module: `spi_regport`

## Requirements
- R1: The first byte of a transfer is a header. After bit-order correction, bit 7 is the direction flag (1 = read, 0 = write) and bits 6:0 are the register address.
- R2: Exactly one data byte follows the header for each register accessed. The block samples input bits on the rising edge of `sclk`. Read data changes after each falling edge, and the first read bit appears after the falling edge that follows the last header bit.
- R3: A written register takes its new value as soon as the eighth data bit has been sampled, before chip-select rises. A change to register 0 therefore applies to the very next byte of the same transfer.
- R4: In a transfer with several data bytes, the register address increases by one after each data byte, for both reads and writes.
- R5: If chip-select rises at a byte boundary and falls again within `STALL_CYCLES` system clocks, the transfer resumes where it stopped.
- R6: If chip-select rises with part of a byte shifted in, the partial byte is discarded, nothing is written, and the next byte is taken as a header. A pause of `STALL_CYCLES` clocks or more at a byte boundary also ends the transfer.
- R7: In four-wire mode, `sdo_oe` is 1 only while read data bits are being shifted out with chip-select low, and `sdio_oe` stays 0.
- R8: Register 0 bit 7, or its mirror bit 0, selects three-wire mode. Read data then appears on `sdio_out` with `sdio_oe` = 1, and `sdo_oe` stays 0.
- R9: Register 0 bit 6, or its mirror bit 1, selects least-significant-bit-first order. Every header, write and read byte then travels in reversed order on the wire.
- R10: While register 0 bit 5, or its mirror bit 2, is 1, registers 1 and up are held at their default values and writes to them are ignored. Register 0 keeps its value and can still be written. Clearing the bit releases the other registers.
- R11: When `rst_n` is 0 or `hw_reset` is 1, register 0 is cleared to 0x00 and register i (i >= 1) is loaded with (37*i + 3) mod 256. Any transfer in progress is dropped and both output enables go to 0.
- R12: Writes to addresses at or above `NUM_REGS` are ignored, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Power-on reset, active low |
| hw_reset | input | 1 | External reset pin, active high, synchronous to `clk` |
| cs_n | input | 1 | Chip-select from the host, active low |
| sclk | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial data from the host (the shared pin's input side) |
| sdo | output | 1 | Read data on the dedicated output pin |
| sdo_oe | output | 1 | Output enable for `sdo`; high-impedance when 0 |
| sdio_out | output | 1 | Read data for the shared pin in three-wire mode |
| sdio_oe | output | 1 | Output enable for the shared pin |

## Verification
The assertions assume that `sclk`, `cs_n` and `sdi` are slow compared with `clk`. Each level must last several system clocks longer than the synchronizer depth, `sdi` must be steady around every rising edge of `sclk`, and `cs_n` must never change in the same cycle as `sclk`. The bench holds every pin level for six system clocks and changes only one pin at a time. It lowers `sclk` after each bit before it touches `cs_n`, so every pause and abort that the assertions watch falls on a clean byte boundary or a clean mid-byte point. It also keeps every pause that is meant to resume well short of `STALL_CYCLES`, and every gap that closes a transfer well past it.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic {
    PH_HEADER = 1'b0,
    PH_DATA   = 1'b1
  } phase_e;

  typedef struct packed {
    logic three_wire;
    logic lsb_first;
    logic soft_rst;
  } mode_t;

  // Reverse the bit order of a byte.
  function automatic logic [7:0] bit_rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // Bring a byte between wire order and register order.
  function automatic logic [7:0] order_byte(input logic [7:0] b, input logic lsb_first);
    return lsb_first ? bit_rev8(b) : b;
  endfunction

  // Value a register takes on reset; the mode register clears.
  function automatic logic [7:0] reg_default(input int unsigned idx);
    return (idx == 0) ? 8'h00 : 8'(idx * 37 + 3);
  endfunction

  // Each mode control is honoured from its own bit or its mirror.
  function automatic mode_t decode_mode(input logic [7:0] r0);
    mode_t m;
    m.three_wire = r0[7] | r0[0];
    m.lsb_first  = r0[6] | r0[1];
    m.soft_rst   = r0[5] | r0[2];
    return m;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= RST_VAL;
        else     pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
  import spi_regport_pkg::*;
#(
  parameter int STALL_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       lsb_first,
  input  logic [7:0] rdata,
  output logic [6:0] addr,
  output logic       wr_stb,
  output logic [7:0] wdata,
  output logic       tx_bit,
  output logic       drive,
  output logic       hdr_done,
  output logic       abort,
  output logic       stall_end
);
  localparam int CNT_W = $clog2(STALL_CYCLES + 1);
  localparam logic [CNT_W-1:0] STALL_LAST = CNT_W'(STALL_CYCLES - 1);

  phase_e           phase;
  logic [2:0]       bit_cnt;
  logic [7:0]       rx_sh, tx_sh;
  logic             is_read, load_pend, tx_valid, sclk_q;
  logic [CNT_W-1:0] stall_cnt;

  logic       rise, fall, byte_done, data_done;
  logic [7:0] rx_next, rx_byte;

  assign rise      = !cs_n && sclk && !sclk_q;
  assign fall      = !cs_n && !sclk && sclk_q;
  assign rx_next   = {rx_sh[6:0], sdi};
  assign rx_byte   = order_byte(rx_next, lsb_first);
  assign byte_done = rise && (bit_cnt == 3'd7);
  assign hdr_done  = byte_done && (phase == PH_HEADER);
  assign data_done = byte_done && (phase == PH_DATA);
  assign wr_stb    = data_done && !is_read;
  assign wdata     = rx_byte;
  assign abort     = cs_n && (bit_cnt != 3'd0);
  assign stall_end = cs_n && (bit_cnt == 3'd0) && (phase == PH_DATA) &&
                     (stall_cnt == STALL_LAST);
  assign drive     = tx_valid && !cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HEADER;
      bit_cnt   <= 3'd0;
      rx_sh     <= 8'h00;
      tx_sh     <= 8'h00;
      tx_bit    <= 1'b0;
      addr      <= 7'd0;
      is_read   <= 1'b0;
      load_pend <= 1'b0;
      tx_valid  <= 1'b0;
      sclk_q    <= 1'b0;
      stall_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (abort || stall_end) begin
        phase     <= PH_HEADER;
        bit_cnt   <= 3'd0;
        is_read   <= 1'b0;
        load_pend <= 1'b0;
        tx_valid  <= 1'b0;
        stall_cnt <= '0;
      end else begin
        stall_cnt <= (cs_n && phase == PH_DATA) ? stall_cnt + 1'b1 : '0;
        if (load_pend) begin
          tx_sh     <= order_byte(rdata, lsb_first);
          load_pend <= 1'b0;
        end
        if (rise) begin
          rx_sh   <= rx_next;
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (hdr_done) begin
          phase     <= PH_DATA;
          addr      <= rx_byte[6:0];
          is_read   <= rx_byte[7];
          load_pend <= rx_byte[7];
          tx_valid  <= 1'b0;
        end
        if (data_done) begin
          addr      <= addr + 7'd1;
          load_pend <= is_read;
        end
        if (fall && phase == PH_DATA && is_read) begin
          tx_bit   <= tx_sh[7];
          tx_sh    <= {tx_sh[6:0], 1'b0};
          tx_valid <= 1'b1;
        end
      end
    end
  end

  // A mid-byte chip-select release leaves the engine waiting for a header (R6).
  assert_abort_to_header_R6: assert property (@(posedge clk) disable iff (rst)
    abort |=> (phase == PH_HEADER && bit_cnt == 3'd0));

  // A completed header always moves on to the data phase (R1).
  assert_header_opens_data_R1: assert property (@(posedge clk) disable iff (rst)
    hdr_done |=> (phase == PH_DATA));

  // Output is driven only while read data is being returned (R7).
  assert_drive_only_read_R7: assert property (@(posedge clk) disable iff (rst)
    drive |-> (is_read && phase == PH_DATA));

  // A pause that outlasts the limit closes the transfer (R6).
  assert_stall_closes_R6: assert property (@(posedge clk) disable iff (rst)
    stall_end |=> (phase == PH_HEADER && !is_read));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regport_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [6:0] waddr,
  input  logic [7:0] wdata,
  input  logic [6:0] raddr,
  output logic [7:0] rdata,
  output logic       three_wire,
  output logic       lsb_first,
  output logic       soft_rst
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0] regs [NUM_REGS];
  mode_t      mode;

  assign mode       = decode_mode(regs[0]);
  assign three_wire = mode.three_wire;
  assign lsb_first  = mode.lsb_first;
  assign soft_rst   = mode.soft_rst;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [6:0] MY_ADDR = 7'(g);
      localparam logic [7:0] DEF     = reg_default(g);
      logic [7:0] q;
      logic       hit;
      assign hit     = wr_stb && (waddr == MY_ADDR);
      assign regs[g] = q;
      if (g == 0) begin : g_mode
        always_ff @(posedge clk) begin
          if (rst)      q <= DEF;
          else if (hit) q <= wdata;
        end
      end else begin : g_cfg
        always_ff @(posedge clk) begin
          if (rst || soft_rst) q <= DEF;
          else if (hit)        q <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    rdata = 8'h00;
    if ({1'b0, raddr} < 8'(NUM_REGS)) rdata = regs[raddr[IDX_W-1:0]];
  end

  // A write to the mode register lands on the strobe cycle (R3).
  assert_mode_write_now_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && waddr == 7'd0) |=> (regs[0] == $past(wdata)));

  generate
    if (NUM_REGS > 1) begin : g_soft_chk
      // Software reset pins the configuration registers to defaults (R10).
      assert_soft_reset_hold_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (regs[1] == reg_default(1)));
    end
  endgenerate
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int STALL_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_reset,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe,
  output logic sdio_out,
  output logic sdio_oe
);
  logic       rst_core;
  logic [2:0] pins_s;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic       wr_stb, tx_bit, drive, hdr_done, abort, stall_end;
  logic       three_wire, lsb_first, soft_rst;

  assign rst_core = !rst_n || hw_reset;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst_core),
    .d   ({cs_n, sclk, sdi}),
    .q   (pins_s)
  );

  spi_serial_engine #(.STALL_CYCLES(STALL_CYCLES)) u_engine (
    .clk       (clk),
    .rst       (rst_core),
    .cs_n      (pins_s[2]),
    .sclk      (pins_s[1]),
    .sdi       (pins_s[0]),
    .lsb_first (lsb_first),
    .rdata     (rdata),
    .addr      (addr),
    .wr_stb    (wr_stb),
    .wdata     (wdata),
    .tx_bit    (tx_bit),
    .drive     (drive),
    .hdr_done  (hdr_done),
    .abort     (abort),
    .stall_end (stall_end)
  );

  spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk        (clk),
    .rst        (rst_core),
    .wr_stb     (wr_stb),
    .waddr      (addr),
    .wdata      (wdata),
    .raddr      (addr),
    .rdata      (rdata),
    .three_wire (three_wire),
    .lsb_first  (lsb_first),
    .soft_rst   (soft_rst)
  );

  assign sdo      = tx_bit;
  assign sdo_oe   = drive && !three_wire;
  assign sdio_out = tx_bit;
  assign sdio_oe  = drive && three_wire;

  // A write strobe never coincides with a header or an abort (R1, R6).
  assert_write_not_header_R1: assert property (@(posedge clk) disable iff (rst_core)
    wr_stb |-> (!hdr_done && !abort && !stall_end));

  // The enables go quiet in the cycle after chip-select is seen high (R7).
  assert_quiet_when_deselected_R7: assert property (@(posedge clk) disable iff (rst_core)
    $rose(pins_s[2]) |=> (!sdo_oe && !sdio_oe));
endmodule

// File: tb/spi_regport_bench.sv
`timescale 1ns/1ps
module spi_regport_bench;
  localparam int HALF  = 6;
  localparam int STALL = 64;
  localparam int NREG  = 16;
  localparam int NVEC  = 8;
  // Each entry: {address[6:0], write data[7:0], expected read-back[7:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {7'd1,   8'hA5, 8'hA5},
    {7'd2,   8'h3C, 8'h3C},
    {7'd15,  8'hFF, 8'hFF},
    {7'd16,  8'h77, 8'h00},
    {7'd127, 8'h12, 8'h00},
    {7'd7,   8'h00, 8'h00},
    {7'd9,   8'h81, 8'h81},
    {7'd14,  8'h5A, 8'h5A}
  };

  logic clk = 1'b0, rst_n = 1'b0, hw_reset = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, sdio_out, sdio_oe;
  logic lsb_m = 1'b0;
  logic done = 1'b0;
  int   checks = 0, failures = 0;

  always #2 clk = ~clk;

  spi_regport #(.NUM_REGS(NREG), .SYNC_STAGES(2), .STALL_CYCLES(STALL)) u_spi_regport (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
  );

  function automatic logic [7:0] flip(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  function automatic logic [7:0] dflt(input int a);
    if (a == 0) return 8'h00;
    return 8'((a * 37 + 3) % 256);
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] b);
    return lsb_m ? flip(b) : b;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] wire_b, input int nb,
                            output logic [7:0] got, output int n4, output int n3);
    got = 8'h00; n4 = 0; n3 = 0;
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = wire_b[i];
      wait_clk(HALF);
      got[i] = sdio_oe ? sdio_out : sdo;
      if (sdo_oe) n4++;
      if (sdio_oe) n3++;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic start_x();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic stop_x();
    cs_n = 1'b1;
    wait_clk(STALL + 20);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] g; int a4, a3;
    shift_bits(enc(b), 8, g, a4, a3);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] d);
    start_x();
    send({1'b0, a});
    send(d);
    stop_x();
  endtask

  task automatic read_reg(input logic [6:0] a, output logic [7:0] v,
                          output int hn4, output int dn4, output int dn3);
    logic [7:0] g; int h3;
    start_x();
    shift_bits(enc({1'b1, a}), 8, g, hn4, h3);
    shift_bits(8'h00, 8, g, dn4, dn3);
    v = lsb_m ? flip(g) : g;
    stop_x();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish (got hang, expected completion)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, g;
    int h4, d4, d3, a4, a3;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R11: reset state
    check("R11 sdo_oe after reset", {7'd0, sdo_oe}, 8'h00);
    check("R11 sdio_oe after reset", {7'd0, sdio_oe}, 8'h00);
    read_reg(7'd3, v, h4, d4, d3);
    check("R11 reg3 default", v, dflt(3));
    read_reg(7'd0, v, h4, d4, d3);
    check("R11 mode reg default", v, 8'h00);

    // R1 R2 R12: vector table, write then read back
    for (int i = 0; i < NVEC; i++) begin
      write_reg(VEC[i][22:16], VEC[i][15:8]);
      read_reg(VEC[i][22:16], v, h4, d4, d3);
      check($sformatf("R1 R2 R12 vector %0d", i), v, VEC[i][7:0]);
    end

    // R7: enables during a four-wire read
    read_reg(7'd2, v, h4, d4, d3);
    check("R7 sdo_oe during header bits", 8'(h4), 8'd0);
    check("R7 sdo_oe during data bits", 8'(d4), 8'd8);
    check("R7 sdio_oe in four-wire", 8'(d3), 8'd0);
    check("R7 sdo_oe after transfer", {7'd0, sdo_oe}, 8'h00);

    // R4: multi-byte write and read with address increment
    start_x(); send({1'b0, 7'd4}); send(8'h11); send(8'h22); send(8'h33); stop_x();
    start_x();
    send({1'b1, 7'd4});
    shift_bits(8'h00, 8, g, a4, a3); check("R4 burst read reg4", g, 8'h11);
    shift_bits(8'h00, 8, g, a4, a3); check("R4 burst read reg5", g, 8'h22);
    shift_bits(8'h00, 8, g, a4, a3); check("R4 burst read reg6", g, 8'h33);
    stop_x();

    // R5: pause between header and data, then between data bytes
    start_x(); send({1'b0, 7'd8});
    cs_n = 1'b1; wait_clk(10); start_x();
    send(8'h99);
    cs_n = 1'b1; wait_clk(10); start_x();
    send(8'h98);
    stop_x();
    read_reg(7'd8, v, h4, d4, d3); check("R5 resumed write reg8", v, 8'h99);
    read_reg(7'd9, v, h4, d4, d3); check("R5 resumed write reg9", v, 8'h98);

    // R6: abort mid-byte, then a quick new header is honoured
    start_x(); send({1'b0, 7'd10});
    shift_bits(8'hE0, 3, g, a4, a3);
    cs_n = 1'b1; wait_clk(10); start_x();
    send({1'b1, 7'd10});
    shift_bits(8'h00, 8, g, a4, a3);
    stop_x();
    check("R6 abort leaves reg10 default", g, dflt(10));

    // R6: a long gap ends the transfer, so the next byte is a header
    write_reg(7'd11, 8'h3A);
    write_reg(7'd12, 8'h44);
    read_reg(7'd11, v, h4, d4, d3); check("R6 timeout reg11", v, 8'h3A);
    read_reg(7'd12, v, h4, d4, d3); check("R6 timeout reg12", v, 8'h44);

    // R3 R9: mode change takes effect on the next byte of the same transfer
    start_x(); send({1'b0, 7'd0}); send(8'h42);
    lsb_m = 1'b1;
    send(8'h6B);
    stop_x();
    read_reg(7'd1, v, h4, d4, d3); check("R3 R9 lsb-first read reg1", v, 8'h6B);
    write_reg(7'd3, 8'h1E);
    read_reg(7'd3, v, h4, d4, d3); check("R9 lsb-first write reg3", v, 8'h1E);
    write_reg(7'd0, 8'h00);
    lsb_m = 1'b0;
    read_reg(7'd3, v, h4, d4, d3); check("R9 msb-first read reg3", v, 8'h1E);

    // R8: three-wire by bit 7 and by mirror bit 0
    write_reg(7'd0, 8'h81);
    read_reg(7'd2, v, h4, d4, d3);
    check("R8 three-wire data", v, 8'h3C);
    check("R8 sdio_oe bits", 8'(d3), 8'd8);
    check("R8 sdo_oe bits", 8'(d4), 8'd0);
    write_reg(7'd0, 8'h00);
    write_reg(7'd0, 8'h01);
    read_reg(7'd2, v, h4, d4, d3);
    check("R8 mirror bit0 sdio_oe bits", 8'(d3), 8'd8);
    write_reg(7'd0, 8'h00);

    // R10: software reset by bit 5
    write_reg(7'd0, 8'h20);
    read_reg(7'd4, v, h4, d4, d3); check("R10 reg4 defaulted", v, dflt(4));
    write_reg(7'd4, 8'h55);
    read_reg(7'd4, v, h4, d4, d3); check("R10 write ignored in soft reset", v, dflt(4));
    read_reg(7'd0, v, h4, d4, d3); check("R10 mode reg kept", v, 8'h20);
    write_reg(7'd0, 8'h00);
    read_reg(7'd4, v, h4, d4, d3); check("R10 reg4 after release", v, dflt(4));
    write_reg(7'd4, 8'h55);
    read_reg(7'd4, v, h4, d4, d3); check("R10 write after release", v, 8'h55);
    // R10: software reset by mirror bit 2
    write_reg(7'd5, 8'h22);
    write_reg(7'd0, 8'h04);
    read_reg(7'd5, v, h4, d4, d3); check("R10 mirror bit2 reg5", v, dflt(5));
    write_reg(7'd0, 8'h00);

    // R11: hardware reset clears the mode register too
    write_reg(7'd0, 8'h42);
    lsb_m = 1'b1;
    read_reg(7'd0, v, h4, d4, d3); check("R9 mode reg readback lsb-first", v, 8'h42);
    hw_reset = 1'b1; wait_clk(3); hw_reset = 1'b0; wait_clk(5);
    lsb_m = 1'b0;
    check("R11 sdo_oe after pin reset", {7'd0, sdo_oe}, 8'h00);
    read_reg(7'd0, v, h4, d4, d3); check("R11 mode reg after pin reset", v, 8'h00);
    read_reg(7'd9, v, h4, d4, d3); check("R11 reg9 after pin reset", v, dflt(9));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule